// File: doc/BRIEF.md
# Trap Entry State Save Unit

This block performs the register bookkeeping a processor core needs on the cycle it takes a trap. The core presents its current trap level, global register level, condition codes, address-space identifier, processor-state and hyper-state words, window pointer, spare-window count, program counter pair and the trap type. It also selects one of three target modes: privileged, hyperprivileged or reset/error state. On a single-cycle `trap_take` strobe the unit computes everything at once and registers the results.

The registered results are the packed trap-state word, the saved PC and NPC, the saved hyper state and the recorded trap type. They also include the new trap level, global level, processor state, hyper state and window pointer. The surrounding core writes these into its own state registers. Vector address generation, the trap-stack storage and instruction fetch sit outside this block. All outputs hold their values between strobes.

Top module: `trap_entry_saver`

## Requirements
- R1: After a synchronous active-low reset every output is zero, including `save_done`. `save_done` is high for exactly the one cycle after each `trap_take` cycle.
- R2: The trap-state word places the window pointer in bits 4:0, the processor state in bits 20:8, the address-space identifier in bits 31:24, the condition codes in bits 39:32 and the global level in bits 42:40. Every other bit is zero.
- R3: When processor-state bit 3 (address mask) is set, the saved PC and NPC keep only their low 32 bits and the upper 32 bits are zero. When it is clear, both are saved at the full 64 bits.
- R4: The new trap level is the current level plus one, modulo 2^TL_W.
- R5: The new global level is the current level plus one. It saturates at MAX_GL (default 3) when `entry_mode` is hyperprivileged (2'b01) or reset/error state (2'b10 or 2'b11). It saturates at MAX_PGL (default 2) when `entry_mode` is privileged (2'b00).
- R6: For trap type 0x024 the window pointer increments by one. For trap types 0x080 to 0x0BF it increases by the spare-window count plus two. For 0x0C0 to 0x0FF it decrements by one. Every result wraps modulo NWIN (default 8).
- R7: For every other trap type, including 0x07F and 0x100, the window pointer is passed through unchanged.
- R8: On a privileged or hyperprivileged entry, the processor state has bit 4 (FP enable) set and bits 3 (address mask) and 1 (interrupt enable) cleared. A privileged entry also sets bit 2 (privileged) and copies bit 8 (little-endian on trap) into bit 9 (current little-endian). The hyper state is left unchanged on a privileged entry.
- R9: A hyperprivileged entry clears processor-state bit 9 and leaves bit 2 as it was. In the hyper state it clears bit 5 (reset/error), sets bit 2 (hyperprivileged) and clears bit 10 (instruction breakpoint enable). All other hyper-state bits, including bit 0 (trap level zero), keep their values.
- R10: A reset/error-state entry clears the processor state except that bit 2 keeps its old value and bit 4 is set. In the hyper state it sets bits 5 and 2, clears bits 10 and 0, and keeps all other bits.
- R11: The saved hyper state equals the hyper state before modification. The recorded trap type equals the incoming type.
- R12: When `trap_take` is low, no output changes, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_take | input | 1 | Single-cycle strobe: commit a trap entry |
| entry_mode | input | 2 | 00 privileged, 01 hyperprivileged, 1x reset/error state |
| trap_type | input | 9 | Trap type of the trap being taken |
| cur_tl | input | 3 | Current trap level |
| cur_gl | input | 3 | Current global register level |
| cur_ccr | input | 8 | Current condition codes |
| cur_asi | input | 8 | Current address-space identifier |
| cur_pstate | input | 13 | Current processor-state word |
| cur_hpstate | input | 12 | Current hyper-state word |
| cur_cwp | input | 5 | Current window pointer |
| cur_cansave | input | 5 | Current count of spare windows |
| cur_pc | input | 64 | PC of the trapping instruction |
| cur_npc | input | 64 | Next PC |
| save_done | output | 1 | High one cycle after a commit |
| tstate_word | output | 64 | Packed trap-state word |
| saved_pc | output | 64 | Saved PC |
| saved_npc | output | 64 | Saved NPC |
| saved_hpstate | output | 12 | Hyper state before the trap |
| saved_tt | output | 9 | Recorded trap type |
| next_tl | output | 3 | Updated trap level |
| next_gl | output | 3 | Updated global level |
| next_pstate | output | 13 | Updated processor state |
| next_hpstate | output | 12 | Updated hyper state |
| next_cwp | output | 5 | Updated window pointer |

## Verification
The assertions check several properties on every cycle. The trap level increments by one on each commit. The global level never exceeds the cap for the selected mode, and the window pointer stays below NWIN. The FP-enable bit is set after each commit, and the saved PC is masked when the address mask is on. Outputs stay stable while no strobe is present, and `save_done` follows the strobe. The exact bit placement in the trap-state word, the window arithmetic at each trap-type boundary and the per-mode rewrite of individual state bits need known input values, so only the bench's directed scenarios can show them.

// File: rtl/trap_entry_pkg.sv
// Package: shared widths, field positions and the entry-mode type for the
// trap entry state save unit. Assumes a 13-bit processor-state word and a
// 12-bit hyper-state word with the bit positions listed here.
package trap_entry_pkg;

    // Entry mode selected by the core for this trap
    typedef enum logic [1:0] {
        MODE_PRIV  = 2'b00,
        MODE_HYPER = 2'b01,
        MODE_RED   = 2'b10,
        MODE_RED2  = 2'b11
    } entry_mode_e;

    // Window movement class derived from the trap type
    typedef enum logic [1:0] {
        WIN_KEEP  = 2'd0,
        WIN_CLEAN = 2'd1,
        WIN_SPILL = 2'd2,
        WIN_FILL  = 2'd3
    } win_move_e;

    localparam int PSTATE_W = 13;
    localparam int HPSTATE_W = 12;
    localparam int CCR_W = 8;
    localparam int ASI_W = 8;
    localparam int CWP_W = 5;
    localparam int ADDR_W = 64;
    localparam int TT_W = 9;
    localparam int TSTATE_W = 64;

    // Processor-state bit positions
    localparam int PS_IE = 1;
    localparam int PS_PRIV = 2;
    localparam int PS_AM = 3;
    localparam int PS_PEF = 4;
    localparam int PS_TLE = 8;
    localparam int PS_CLE = 9;

    // Hyper-state bit positions
    localparam int HS_TLZ = 0;
    localparam int HS_HPRIV = 2;
    localparam int HS_RED = 5;
    localparam int HS_IBE = 10;

    // Trap-state word field offsets (decoded by the trap-return logic)
    localparam int TS_CWP_LO = 0;
    localparam int TS_PS_LO = 8;
    localparam int TS_ASI_LO = 24;
    localparam int TS_CCR_LO = 32;
    localparam int TS_GL_LO = 40;

    // Trap types that move the window
    localparam logic [TT_W-1:0] TT_CLEAN = 9'h024;

endpackage

// File: rtl/tstate_packer.sv
// Module: tstate_packer
// Packs global level, condition codes, ASI, processor state and window
// pointer into the fixed trap-state layout. Purely combinational.
// Assumes GL_W is at most 3 so the global level fits bits 42:40.
module tstate_packer
    import trap_entry_pkg::*;
#(
    parameter int GL_W = 3
) (
    input  logic [GL_W-1:0]     gl,
    input  logic [CCR_W-1:0]    ccr,
    input  logic [ASI_W-1:0]    asi,
    input  logic [PSTATE_W-1:0] pstate,
    input  logic [CWP_W-1:0]    cwp,
    output logic [TSTATE_W-1:0] word
);

    // Place each field at its offset, all unused bits zero
    always_comb begin
        word = '0;
        word[TS_CWP_LO +: CWP_W]   = cwp;
        word[TS_PS_LO  +: PSTATE_W] = pstate;
        word[TS_ASI_LO +: ASI_W]   = asi;
        word[TS_CCR_LO +: CCR_W]   = ccr;
        word[TS_GL_LO  +: GL_W]    = gl;
    end

endmodule

// File: rtl/gl_saturator.sv
// Module: gl_saturator
// Computes the next global level: current plus one, capped at MAX_GL for
// hyperprivileged or reset-state entry and at MAX_PGL for privileged entry.
// Assumes MAX_PGL <= MAX_GL < 2**GL_W.
module gl_saturator
    import trap_entry_pkg::*;
#(
    parameter int GL_W = 3,
    parameter int MAX_GL = 3,
    parameter int MAX_PGL = 2
) (
    input  logic [GL_W-1:0] gl,
    input  entry_mode_e     mode,
    output logic [GL_W-1:0] gl_next
);

    localparam int SUM_W = GL_W + 1;
    localparam logic [SUM_W-1:0] CAP_H = SUM_W'(MAX_GL);
    localparam logic [SUM_W-1:0] CAP_P = SUM_W'(MAX_PGL);

    logic [SUM_W-1:0] inc;
    logic [SUM_W-1:0] cap;

    // Pick the cap for the target mode and saturate the increment
    always_comb begin
        inc = {1'b0, gl} + SUM_W'(1);
        cap = (mode == MODE_PRIV) ? CAP_P : CAP_H;
        gl_next = (inc > cap) ? cap[GL_W-1:0] : inc[GL_W-1:0];
    end

endmodule

// File: rtl/cwp_mover.sv
// Module: cwp_mover
// Classifies the trap type and moves the window pointer: clean-window trap
// +1, spill range +spare+2, fill range -1, others unchanged; result modulo
// NWIN. Assumes the incoming pointer may exceed NWIN and reduces it first.
module cwp_mover
    import trap_entry_pkg::*;
#(
    parameter int NWIN = 8
) (
    input  logic [TT_W-1:0]  tt,
    input  logic [CWP_W-1:0] cwp,
    input  logic [CWP_W-1:0] cansave,
    output win_move_e        move,
    output logic [CWP_W-1:0] cwp_next
);

    localparam int SUM_W = CWP_W + 2;
    localparam logic [SUM_W-1:0] NW = SUM_W'(NWIN);

    logic [SUM_W-1:0] base;
    logic [SUM_W-1:0] raw;

    // Decode the trap-type range into a movement class
    always_comb begin
        if (tt == TT_CLEAN)
            move = WIN_CLEAN;
        else if (!tt[8] && tt[7:6] == 2'b10)
            move = WIN_SPILL;
        else if (!tt[8] && tt[7:6] == 2'b11)
            move = WIN_FILL;
        else
            move = WIN_KEEP;
    end

    // Form the unreduced pointer for the selected movement and wrap it
    always_comb begin
        base = {2'b00, cwp} % NW;
        unique case (move)
            WIN_CLEAN: raw = base + SUM_W'(1);
            WIN_SPILL: raw = base + {2'b00, cansave} + SUM_W'(2);
            WIN_FILL:  raw = base + NW - SUM_W'(1);
            default:   raw = {2'b00, cwp};
        endcase
        if (move == WIN_KEEP)
            cwp_next = cwp;
        else
            cwp_next = CWP_W'(raw % NW);
    end

endmodule

// File: rtl/state_rewriter.sv
// Module: state_rewriter
// Rewrites the processor-state and hyper-state words for the selected
// entry mode. Purely combinational; the old words are not modified here.
module state_rewriter
    import trap_entry_pkg::*;
(
    input  entry_mode_e          mode,
    input  logic [PSTATE_W-1:0]  pstate,
    input  logic [HPSTATE_W-1:0] hpstate,
    output logic [PSTATE_W-1:0]  pstate_next,
    output logic [HPSTATE_W-1:0] hpstate_next
);

    // Processor-state rewrite per target mode
    always_comb begin
        pstate_next = pstate;
        unique case (mode)
            MODE_PRIV: begin
                pstate_next[PS_PEF]  = 1'b1;
                pstate_next[PS_AM]   = 1'b0;
                pstate_next[PS_IE]   = 1'b0;
                pstate_next[PS_PRIV] = 1'b1;
                pstate_next[PS_CLE]  = pstate[PS_TLE];
            end
            MODE_HYPER: begin
                pstate_next[PS_PEF] = 1'b1;
                pstate_next[PS_AM]  = 1'b0;
                pstate_next[PS_IE]  = 1'b0;
                pstate_next[PS_CLE] = 1'b0;
            end
            default: begin
                pstate_next          = '0;
                pstate_next[PS_PRIV] = pstate[PS_PRIV];
                pstate_next[PS_PEF]  = 1'b1;
            end
        endcase
    end

    // Hyper-state rewrite per target mode
    always_comb begin
        hpstate_next = hpstate;
        unique case (mode)
            MODE_PRIV: hpstate_next = hpstate;
            MODE_HYPER: begin
                hpstate_next[HS_RED]   = 1'b0;
                hpstate_next[HS_HPRIV] = 1'b1;
                hpstate_next[HS_IBE]   = 1'b0;
            end
            default: begin
                hpstate_next[HS_RED]   = 1'b1;
                hpstate_next[HS_HPRIV] = 1'b1;
                hpstate_next[HS_IBE]   = 1'b0;
                hpstate_next[HS_TLZ]   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/trap_entry_saver.sv
// Module: trap_entry_saver (top)
// Computes every trap-entry register update from the current state and
// commits all of them in one clock on the trap_take strobe. Outputs hold
// between strobes. Assumes trap_take is a single-cycle pulse.
module trap_entry_saver
    import trap_entry_pkg::*;
#(
    parameter int TL_W = 3,
    parameter int GL_W = 3,
    parameter int MAX_GL = 3,
    parameter int MAX_PGL = 2,
    parameter int NWIN = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trap_take,
    input  logic [1:0]           entry_mode,
    input  logic [TT_W-1:0]      trap_type,
    input  logic [TL_W-1:0]      cur_tl,
    input  logic [GL_W-1:0]      cur_gl,
    input  logic [CCR_W-1:0]     cur_ccr,
    input  logic [ASI_W-1:0]     cur_asi,
    input  logic [PSTATE_W-1:0]  cur_pstate,
    input  logic [HPSTATE_W-1:0] cur_hpstate,
    input  logic [CWP_W-1:0]     cur_cwp,
    input  logic [CWP_W-1:0]     cur_cansave,
    input  logic [ADDR_W-1:0]    cur_pc,
    input  logic [ADDR_W-1:0]    cur_npc,
    output logic                 save_done,
    output logic [TSTATE_W-1:0]  tstate_word,
    output logic [ADDR_W-1:0]    saved_pc,
    output logic [ADDR_W-1:0]    saved_npc,
    output logic [HPSTATE_W-1:0] saved_hpstate,
    output logic [TT_W-1:0]      saved_tt,
    output logic [TL_W-1:0]      next_tl,
    output logic [GL_W-1:0]      next_gl,
    output logic [PSTATE_W-1:0]  next_pstate,
    output logic [HPSTATE_W-1:0] next_hpstate,
    output logic [CWP_W-1:0]     next_cwp
);

    localparam int HALF_W = ADDR_W / 2;

    entry_mode_e          mode;
    win_move_e            win_move;
    logic [TSTATE_W-1:0]  ts_d;
    logic [GL_W-1:0]      gl_d;
    logic [CWP_W-1:0]     cwp_d;
    logic [PSTATE_W-1:0]  ps_d;
    logic [HPSTATE_W-1:0] hs_d;
    logic [ADDR_W-1:0]    pc_mask;
    logic [ADDR_W-1:0]    pc_d;
    logic [ADDR_W-1:0]    npc_d;

    assign mode = entry_mode_e'(entry_mode);

    tstate_packer #(.GL_W(GL_W)) u_pack (
        .gl     (cur_gl),
        .ccr    (cur_ccr),
        .asi    (cur_asi),
        .pstate (cur_pstate),
        .cwp    (cur_cwp),
        .word   (ts_d)
    );

    gl_saturator #(.GL_W(GL_W), .MAX_GL(MAX_GL), .MAX_PGL(MAX_PGL)) u_gl (
        .gl      (cur_gl),
        .mode    (mode),
        .gl_next (gl_d)
    );

    cwp_mover #(.NWIN(NWIN)) u_cwp (
        .tt       (trap_type),
        .cwp      (cur_cwp),
        .cansave  (cur_cansave),
        .move     (win_move),
        .cwp_next (cwp_d)
    );

    state_rewriter u_rw (
        .mode         (mode),
        .pstate       (cur_pstate),
        .hpstate      (cur_hpstate),
        .pstate_next  (ps_d),
        .hpstate_next (hs_d)
    );

    // Narrow the saved PC pair to 32 bits when the address mask is on
    always_comb begin
        pc_mask = cur_pstate[PS_AM] ? {{HALF_W{1'b0}}, {HALF_W{1'b1}}} : '1;
        pc_d    = cur_pc & pc_mask;
        npc_d   = cur_npc & pc_mask;
    end

    // Commit every update on the strobe; hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            save_done     <= 1'b0;
            tstate_word   <= '0;
            saved_pc      <= '0;
            saved_npc     <= '0;
            saved_hpstate <= '0;
            saved_tt      <= '0;
            next_tl       <= '0;
            next_gl       <= '0;
            next_pstate   <= '0;
            next_hpstate  <= '0;
            next_cwp      <= '0;
        end else begin
            save_done <= trap_take;
            if (trap_take) begin
                tstate_word   <= ts_d;
                saved_pc      <= pc_d;
                saved_npc     <= npc_d;
                saved_hpstate <= cur_hpstate;
                saved_tt      <= trap_type;
                next_tl       <= cur_tl + TL_W'(1);
                next_gl       <= gl_d;
                next_pstate   <= ps_d;
                next_hpstate  <= hs_d;
                next_cwp      <= cwp_d;
            end
        end
    end

    // The movement class is only needed inside the window unit
    logic unused_move;
    assign unused_move = ^win_move;

endmodule

// File: rtl/trap_entry_saver_sva.sv
// Module: trap_entry_saver_sva
// Checker for trap_entry_saver, bound to every instance of the top.
module trap_entry_saver_sva
    import trap_entry_pkg::*;
#(
    parameter int TL_W = 3,
    parameter int GL_W = 3,
    parameter int MAX_GL = 3,
    parameter int MAX_PGL = 2,
    parameter int NWIN = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 trap_take,
    input logic [1:0]           entry_mode,
    input logic [TL_W-1:0]      cur_tl,
    input logic [PSTATE_W-1:0]  cur_pstate,
    input logic                 save_done,
    input logic [TSTATE_W-1:0]  tstate_word,
    input logic [ADDR_W-1:0]    saved_pc,
    input logic [TL_W-1:0]      next_tl,
    input logic [GL_W-1:0]      next_gl,
    input logic [PSTATE_W-1:0]  next_pstate,
    input logic [CWP_W-1:0]     next_cwp
);

    p_done_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> save_done);

    p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_take |=> !save_done);

    p_tl_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> next_tl == TL_W'($past(cur_tl) + TL_W'(1)));

    p_gl_priv_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_take && entry_mode == 2'b00) |=> int'(next_gl) <= MAX_PGL);

    p_gl_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> int'(next_gl) <= MAX_GL);

    p_cwp_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> int'(next_cwp) < NWIN);

    p_pc_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_take && cur_pstate[PS_AM]) |=> saved_pc[ADDR_W-1:32] == '0);

    p_pef_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> next_pstate[PS_PEF]);

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_take |=> ($stable(tstate_word) && $stable(next_tl)
                        && $stable(next_cwp) && $stable(next_pstate)));

endmodule

bind trap_entry_saver trap_entry_saver_sva #(
    .TL_W(TL_W), .GL_W(GL_W), .MAX_GL(MAX_GL), .MAX_PGL(MAX_PGL), .NWIN(NWIN)
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .trap_take   (trap_take),
    .entry_mode  (entry_mode),
    .cur_tl      (cur_tl),
    .cur_pstate  (cur_pstate),
    .save_done   (save_done),
    .tstate_word (tstate_word),
    .saved_pc    (saved_pc),
    .next_tl     (next_tl),
    .next_gl     (next_gl),
    .next_pstate (next_pstate),
    .next_cwp    (next_cwp)
);

// File: tb/trap_entry_saver_bench.sv
// Directed bench for trap_entry_saver: one task per scenario.
module trap_entry_saver_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_take = 1'b0;
    logic [1:0]  entry_mode = 2'b00;
    logic [8:0]  trap_type = '0;
    logic [2:0]  cur_tl = '0;
    logic [2:0]  cur_gl = '0;
    logic [7:0]  cur_ccr = '0;
    logic [7:0]  cur_asi = '0;
    logic [12:0] cur_pstate = '0;
    logic [11:0] cur_hpstate = '0;
    logic [4:0]  cur_cwp = '0;
    logic [4:0]  cur_cansave = '0;
    logic [63:0] cur_pc = '0;
    logic [63:0] cur_npc = '0;

    logic        save_done;
    logic [63:0] tstate_word;
    logic [63:0] saved_pc;
    logic [63:0] saved_npc;
    logic [11:0] saved_hpstate;
    logic [8:0]  saved_tt;
    logic [2:0]  next_tl;
    logic [2:0]  next_gl;
    logic [12:0] next_pstate;
    logic [11:0] next_hpstate;
    logic [4:0]  next_cwp;

    int n_checks = 0;
    int n_fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_entry_saver u_trap_entry_saver (
        .clk(clk), .rst_n(rst_n), .trap_take(trap_take), .entry_mode(entry_mode),
        .trap_type(trap_type), .cur_tl(cur_tl), .cur_gl(cur_gl), .cur_ccr(cur_ccr),
        .cur_asi(cur_asi), .cur_pstate(cur_pstate), .cur_hpstate(cur_hpstate),
        .cur_cwp(cur_cwp), .cur_cansave(cur_cansave), .cur_pc(cur_pc),
        .cur_npc(cur_npc), .save_done(save_done), .tstate_word(tstate_word),
        .saved_pc(saved_pc), .saved_npc(saved_npc), .saved_hpstate(saved_hpstate),
        .saved_tt(saved_tt), .next_tl(next_tl), .next_gl(next_gl),
        .next_pstate(next_pstate), .next_hpstate(next_hpstate), .next_cwp(next_cwp)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Apply one strobe at a falling edge; results are visible at the next one
    task automatic take_trap();
        trap_take = 1'b1;
        @(negedge clk);
        trap_take = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "done", 64'(save_done), 64'h0);
        check("R1", "tstate", tstate_word, 64'h0);
        check("R1", "pc", saved_pc, 64'h0);
        check("R1", "cwp/tl/gl", {50'h0, next_cwp, next_tl, next_gl, next_pstate[2:0]}, 64'h0);
    endtask

    task automatic t_pack();
        entry_mode = 2'b01; trap_type = 9'h031;
        cur_gl = 3'd2; cur_ccr = 8'hA5; cur_asi = 8'h3C;
        cur_pstate = 13'h1ABC; cur_cwp = 5'd6; cur_tl = 3'd3;
        take_trap();
        check("R2", "tstate", tstate_word,
              (64'd2 << 40) | (64'hA5 << 32) | (64'h3C << 24) | (64'h1ABC << 8) | 64'd6);
        check("R4", "tl", 64'(next_tl), 64'd4);
        check("R1", "done pulse", 64'(save_done), 64'h1);
        @(negedge clk);
        check("R1", "done drop", 64'(save_done), 64'h0);
        cur_tl = 3'd7;
        take_trap();
        check("R4", "tl wrap", 64'(next_tl), 64'd0);
    endtask

    task automatic t_pcmask();
        cur_pc = 64'hDEAD_BEEF_1234_5678; cur_npc = 64'hCAFE_F00D_0000_0010;
        cur_pstate = 13'h0008;
        take_trap();
        check("R3", "pc masked", saved_pc, 64'h1234_5678);
        check("R3", "npc masked", saved_npc, 64'h0000_0010);
        cur_pstate = 13'h0000;
        take_trap();
        check("R3", "pc full", saved_pc, 64'hDEAD_BEEF_1234_5678);
        check("R3", "npc full", saved_npc, 64'hCAFE_F00D_0000_0010);
    endtask

    task automatic t_gl();
        entry_mode = 2'b00; cur_gl = 3'd1; take_trap();
        check("R5", "priv gl 1", 64'(next_gl), 64'd2);
        cur_gl = 3'd2; take_trap();
        check("R5", "priv gl sat", 64'(next_gl), 64'd2);
        entry_mode = 2'b01; take_trap();
        check("R5", "hyper gl 2", 64'(next_gl), 64'd3);
        cur_gl = 3'd3; take_trap();
        check("R5", "hyper gl sat", 64'(next_gl), 64'd3);
        entry_mode = 2'b11; cur_gl = 3'd6; take_trap();
        check("R5", "red gl sat", 64'(next_gl), 64'd3);
    endtask

    task automatic t_cwp();
        entry_mode = 2'b00;
        trap_type = 9'h024; cur_cwp = 5'd7; take_trap();
        check("R6", "clean wrap", 64'(next_cwp), 64'd0);
        trap_type = 9'h080; cur_cwp = 5'd5; cur_cansave = 5'd3; take_trap();
        check("R6", "spill low", 64'(next_cwp), 64'd2);
        trap_type = 9'h0BF; cur_cwp = 5'd1; cur_cansave = 5'd0; take_trap();
        check("R6", "spill high", 64'(next_cwp), 64'd3);
        trap_type = 9'h0C0; cur_cwp = 5'd0; take_trap();
        check("R6", "fill wrap", 64'(next_cwp), 64'd7);
        trap_type = 9'h0FF; cur_cwp = 5'd3; take_trap();
        check("R6", "fill high", 64'(next_cwp), 64'd2);
        trap_type = 9'h07F; cur_cwp = 5'd4; take_trap();
        check("R7", "below spill", 64'(next_cwp), 64'd4);
        trap_type = 9'h100; cur_cwp = 5'd6; take_trap();
        check("R7", "trap instr", 64'(next_cwp), 64'd6);
        trap_type = 9'h025; cur_cwp = 5'd2; take_trap();
        check("R7", "near clean", 64'(next_cwp), 64'd2);
    endtask

    task automatic t_priv();
        entry_mode = 2'b00; cur_pstate = 13'h114A; cur_hpstate = 12'h481;
        trap_type = 9'h034;
        take_trap();
        check("R8", "pstate", 64'(next_pstate), 64'h1354);
        check("R8", "hpstate kept", 64'(next_hpstate), 64'h481);
        check("R11", "saved hs", 64'(saved_hpstate), 64'h481);
        check("R11", "tt", 64'(saved_tt), 64'h034);
    endtask

    task automatic t_hyper();
        entry_mode = 2'b01; cur_pstate = 13'h0A02; cur_hpstate = 12'h4A1;
        trap_type = 9'h068;
        take_trap();
        check("R9", "pstate", 64'(next_pstate), 64'h0810);
        check("R9", "hpstate", 64'(next_hpstate), 64'h085);
        check("R11", "saved hs", 64'(saved_hpstate), 64'h4A1);
        check("R11", "tt", 64'(saved_tt), 64'h068);
    endtask

    task automatic t_red();
        entry_mode = 2'b10; cur_pstate = 13'h1FFF; cur_hpstate = 12'h481;
        take_trap();
        check("R10", "pstate priv kept", 64'(next_pstate), 64'h014);
        check("R10", "hpstate", 64'(next_hpstate), 64'h0A4);
        entry_mode = 2'b11; cur_pstate = 13'h1FFB;
        take_trap();
        check("R10", "pstate priv clear", 64'(next_pstate), 64'h010);
    endtask

    task automatic t_hold();
        logic [63:0] ts0;
        logic [12:0] ps0;
        logic [4:0]  cw0;
        ts0 = tstate_word; ps0 = next_pstate; cw0 = next_cwp;
        cur_gl = 3'd5; cur_ccr = 8'h11; cur_pstate = 13'h0F0F; cur_cwp = 5'd1;
        trap_type = 9'h024; entry_mode = 2'b00; cur_pc = 64'h55;
        repeat (3) @(negedge clk);
        check("R12", "tstate hold", tstate_word, ts0);
        check("R12", "pstate hold", 64'(next_pstate), 64'(ps0));
        check("R12", "cwp hold", 64'(next_cwp), 64'(cw0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_pack();
        t_pcmask();
        t_gl();
        t_cwp();
        t_priv();
        t_hyper();
        t_red();
        t_hold();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule